// File: doc/BRIEF.md
# Service Interface Bridge Register Block

This block holds the 64-bit configuration and status registers of a service-interface host bridge. Two requesters can reach the same registers. A scan-style configuration port addresses them by byte address, and its register number is the address shifted right by three. A memory-mapped port sees the same registers through a window whose first word is the base-address register, so its register number is the byte address shifted right by three plus ten. Every access carries one whole 64-bit word. Bit 63 of the data bus is the most significant byte, and that byte comes first in big-endian order.

Several register numbers do not hold storage of their own. They are atomic aliases that modify another register. Writes to numbers 1 and 2 AND or OR their data into the fault register. Writes to numbers 18 and 19 set or clear bits of the control register. Only the scan port may change the region base-address register. The block exports the masked base address and the enable bit of that register, and it pulses a remap flag whenever a change could move the mapped region. The interrupt status word is sampled from an input and cannot be written. Writes that are refused or that hit an empty number pulse an error flag.

Top module: `svc_bridge_regs`

## Requirements
- R1: After reset every register reads zero. The exception is the region base register (number 10), which reads `DEF_BAR & 0x0003_FFFF_FFF0_0000` with bit 0 set. After reset `region_en` is 1.
- R2: On the scan port the register number is `sc_addr >> 3`. On the memory-mapped port it is `(mm_addr >> 3) + 10`. Memory-mapped byte address 0x00 therefore reaches register 10, and byte address 0x20 reaches register 14.
- R3: Register 0 (the fault register) is written directly. A write to number 1 stores `fault & data`. A write to number 2 stores `fault | data`.
- R4: Register 14 (control) is written directly. A write to number 18 stores `ctrl | data`. A write to number 19 stores `ctrl & ~data`.
- R5: A scan write to register 10 stores `data & 0x0003_FFFF_FFF0_0001`. A memory-mapped write to register 10 leaves the register unchanged and raises `err_pulse`.
- R6: A write to register 11 (the secondary base) stores `data & 0x0003_FFFF_0000_0000`.
- R7: A read of any number outside {0, 6, 7, 10, 11, 14, 15, 20, 21} returns all ones. This includes the alias numbers 1, 2, 18 and 19. A write to any number outside that set and outside the alias set changes nothing and raises `err_pulse` for exactly one cycle.
- R8: A read of register 21 returns the value that `stat_in` had one cycle earlier. A write to register 21 is ignored and raises `err_pulse`.
- R9: When both ports request in the same cycle, the scan port is served. `mm_ready` stays low while `sc_req` is high. The held memory-mapped access completes in the first cycle in which `sc_req` is low.
- R10: Read data and a one-cycle `rvalid` pulse appear on the requesting port in the cycle after the access is accepted. Writes never raise `rvalid`.
- R11: `region_base` equals register 10 ANDed with 0x0003_FFFF_FFF0_0000, and `region_en` equals its bit 0. `remap_pulse` is high for one cycle after an accepted scan write to register 10 when the old enable or the new enable is set.
- R12: Registers 6, 7, 15 and 20 store and return all 64 bits of written data.
- R13: `err_pulse` is high in the cycle after the refused write and low again in the following cycle, unless that cycle also accepts a refused write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sc_req | input | 1 | Scan port access request |
| sc_we | input | 1 | Scan port write (1) or read (0) |
| sc_addr | input | ADDR_W | Scan port byte address |
| sc_wdata | input | 64 | Scan port write data |
| sc_ready | output | 1 | Scan port accepts the request this cycle |
| sc_rdata | output | 64 | Scan port read data |
| sc_rvalid | output | 1 | Scan port read data valid |
| mm_req | input | 1 | Memory-mapped port access request |
| mm_we | input | 1 | Memory-mapped port write (1) or read (0) |
| mm_addr | input | ADDR_W | Memory-mapped port byte address |
| mm_wdata | input | 64 | Memory-mapped port write data |
| mm_ready | output | 1 | Memory-mapped port accepts the request this cycle |
| mm_rdata | output | 64 | Memory-mapped port read data |
| mm_rvalid | output | 1 | Memory-mapped port read data valid |
| stat_in | input | 64 | Interrupt status bits sampled into register 21 |
| region_base | output | 64 | Masked region base address |
| region_en | output | 1 | Region enable |
| remap_pulse | output | 1 | Region must be remapped |
| err_pulse | output | 1 | Refused or unmatched write |

## Verification
A corrupted register stays hidden until someone reads it. Its effect then appears on the reading port's data exactly one cycle after the read is accepted, and the sweeps read every register number through both ports after each write. An index decode error shows up at once as all-ones data or as a spurious or missing error pulse in the cycle after the write. A base register that holds the wrong value is visible on `region_base` and `region_en` in the cycle after any write. A wrong arbitration grant shows up as a response on the wrong port in that same next cycle.

// File: rtl/svcb_pkg.sv
package svcb_pkg;
  localparam int DATA_W = 64;

  // register numbers whose position is behaviour (decoded by software)
  localparam int IX_FAULT     = 0;
  localparam int IX_FAULT_AND = 1;
  localparam int IX_FAULT_OR  = 2;
  localparam int IX_BASE      = 10;
  localparam int IX_BASE2     = 11;
  localparam int IX_CTRL      = 14;
  localparam int IX_CTRL_SET  = 18;
  localparam int IX_CTRL_CLR  = 19;
  localparam int IX_STAT      = 21;
  localparam int MM_IX_OFS    = 10;

  localparam int PLAIN_N = 4;

  localparam logic [DATA_W-1:0] BASE_ADDR_MASK = 64'h0003_FFFF_FFF0_0000;
  localparam logic [DATA_W-1:0] BASE_EN_BIT    = 64'h0000_0000_0000_0001;
  localparam logic [DATA_W-1:0] BASE2_MASK     = 64'h0003_FFFF_0000_0000;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_LOAD,
    OP_AND,
    OP_OR,
    OP_CLR
  } op_e;

  // register numbers of the plain read/write words
  function automatic int plain_ix(int i);
    case (i)
      0:       return 6;
      1:       return 7;
      2:       return 15;
      default: return 20;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] apply_op(op_e op, logic [DATA_W-1:0] cur,
                                                 logic [DATA_W-1:0] d);
    case (op)
      OP_LOAD: return d;
      OP_AND:  return cur & d;
      OP_OR:   return cur | d;
      OP_CLR:  return cur & ~d;
      default: return cur;
    endcase
  endfunction
endpackage

// File: rtl/svcb_arb.sv
module svcb_arb
  import svcb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 6
) (
  input  logic              sc_req,
  input  logic              sc_we,
  input  logic [ADDR_W-1:0] sc_addr,
  input  logic [DATA_W-1:0] sc_wdata,
  output logic              sc_ready,
  input  logic              mm_req,
  input  logic              mm_we,
  input  logic [ADDR_W-1:0] mm_addr,
  input  logic [DATA_W-1:0] mm_wdata,
  output logic              mm_ready,
  output logic              acc_vld,
  output logic              acc_we,
  output logic              acc_scan,
  output logic [IDX_W-1:0]  acc_idx,
  output logic [DATA_W-1:0] acc_wdata
);
  localparam int WORD_W = ADDR_W - 3;

  logic [IDX_W-1:0] sc_idx;
  logic [IDX_W-1:0] mm_idx;
  logic             unused_lsb;

  assign unused_lsb = ^{sc_addr[2:0], mm_addr[2:0]};

  assign sc_idx = IDX_W'(sc_addr[ADDR_W-1:3]);
  assign mm_idx = IDX_W'(mm_addr[ADDR_W-1:3]) + IDX_W'(MM_IX_OFS);

  // scan port has fixed priority
  assign sc_ready = 1'b1;
  assign mm_ready = ~sc_req;

  always_comb begin
    acc_scan  = sc_req;
    acc_vld   = sc_req | mm_req;
    if (sc_req) begin
      acc_we    = sc_we;
      acc_idx   = sc_idx;
      acc_wdata = sc_wdata;
    end else begin
      acc_we    = mm_we;
      acc_idx   = mm_idx;
      acc_wdata = mm_wdata;
    end
  end

  localparam int UNUSED_WORD_W = WORD_W;
endmodule

// File: rtl/svcb_regfile.sv
module svcb_regfile
  import svcb_pkg::*;
#(
  parameter int                IDX_W   = 6,
  parameter logic [DATA_W-1:0] DEF_BAR = 64'h0001_2345_6780_0000
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           acc_vld,
  input  logic                           acc_we,
  input  logic                           acc_scan,
  input  logic [IDX_W-1:0]               acc_idx,
  input  logic [DATA_W-1:0]              acc_wdata,
  input  logic [DATA_W-1:0]              stat_in,
  output logic [DATA_W-1:0]              fir_q,
  output logic [DATA_W-1:0]              ctl_q,
  output logic [DATA_W-1:0]              bar_q,
  output logic [DATA_W-1:0]              bar2_q,
  output logic [DATA_W-1:0]              stat_q,
  output logic [PLAIN_N-1:0][DATA_W-1:0] plain_q,
  output logic                           err_pulse,
  output logic                           remap_pulse
);
  localparam logic [DATA_W-1:0] BAR_KEEP  = BASE_ADDR_MASK | BASE_EN_BIT;
  localparam logic [DATA_W-1:0] BAR_RESET = (DEF_BAR & BASE_ADDR_MASK) | BASE_EN_BIT;

  logic               wr;
  op_e                fault_op;
  op_e                ctrl_op;
  logic               bar_ld;
  logic               bar2_ld;
  logic               err_d;
  logic               remap_d;
  logic               fir_en;
  logic               ctl_en;
  logic [DATA_W-1:0]  fir_d;
  logic [DATA_W-1:0]  ctl_d;
  logic [DATA_W-1:0]  bar_d;
  logic [DATA_W-1:0]  bar2_d;
  logic [PLAIN_N-1:0] plain_sel;
  logic               plain_hit;

  assign wr = acc_vld & acc_we;

  // plain words: one storage register per entry
  for (genvar g = 0; g < PLAIN_N; g++) begin : g_plain
    logic en;
    assign plain_sel[g] = (acc_idx == IDX_W'(plain_ix(g)));
    assign en           = wr & plain_sel[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        plain_q[g] <= '0;
      end else if (en) begin
        plain_q[g] <= acc_wdata;
      end
    end
  end

  assign plain_hit = |plain_sel;

  // write decode
  always_comb begin
    fault_op = OP_NONE;
    ctrl_op  = OP_NONE;
    bar_ld   = 1'b0;
    bar2_ld  = 1'b0;
    err_d    = 1'b0;
    if (wr) begin
      case (acc_idx)
        IDX_W'(IX_FAULT):     fault_op = OP_LOAD;
        IDX_W'(IX_FAULT_AND): fault_op = OP_AND;
        IDX_W'(IX_FAULT_OR):  fault_op = OP_OR;
        IDX_W'(IX_CTRL):      ctrl_op  = OP_LOAD;
        IDX_W'(IX_CTRL_SET):  ctrl_op  = OP_OR;
        IDX_W'(IX_CTRL_CLR):  ctrl_op  = OP_CLR;
        IDX_W'(IX_BASE): begin
          if (acc_scan) bar_ld = 1'b1;
          else          err_d  = 1'b1;
        end
        IDX_W'(IX_BASE2):     bar2_ld  = 1'b1;
        IDX_W'(IX_STAT):      err_d    = 1'b1;
        default:              err_d    = ~plain_hit;
      endcase
    end
  end

  // next-state values
  always_comb begin
    fir_en  = (fault_op != OP_NONE);
    ctl_en  = (ctrl_op != OP_NONE);
    fir_d   = apply_op(fault_op, fir_q, acc_wdata);
    ctl_d   = apply_op(ctrl_op, ctl_q, acc_wdata);
    bar_d   = acc_wdata & BAR_KEEP;
    bar2_d  = acc_wdata & BASE2_MASK;
    remap_d = bar_ld & (bar_q[0] | acc_wdata[0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fir_q       <= '0;
      ctl_q       <= '0;
      bar_q       <= BAR_RESET;
      bar2_q      <= '0;
      stat_q      <= '0;
      err_pulse   <= 1'b0;
      remap_pulse <= 1'b0;
    end else begin
      if (fir_en)  fir_q  <= fir_d;
      if (ctl_en)  ctl_q  <= ctl_d;
      if (bar_ld)  bar_q  <= bar_d;
      if (bar2_ld) bar2_q <= bar2_d;
      stat_q      <= stat_in;
      err_pulse   <= err_d;
      remap_pulse <= remap_d;
    end
  end
endmodule

// File: rtl/svcb_readback.sv
module svcb_readback
  import svcb_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           acc_vld,
  input  logic                           acc_we,
  input  logic                           acc_scan,
  input  logic [IDX_W-1:0]               acc_idx,
  input  logic [DATA_W-1:0]              fir_q,
  input  logic [DATA_W-1:0]              ctl_q,
  input  logic [DATA_W-1:0]              bar_q,
  input  logic [DATA_W-1:0]              bar2_q,
  input  logic [DATA_W-1:0]              stat_q,
  input  logic [PLAIN_N-1:0][DATA_W-1:0] plain_q,
  output logic [DATA_W-1:0]              sc_rdata,
  output logic                           sc_rvalid,
  output logic [DATA_W-1:0]              mm_rdata,
  output logic                           mm_rvalid
);
  logic [DATA_W-1:0] rd_val;
  logic              rd;
  logic              sc_ld;
  logic              mm_ld;

  always_comb begin
    case (acc_idx)
      IDX_W'(IX_FAULT): rd_val = fir_q;
      IDX_W'(IX_BASE):  rd_val = bar_q;
      IDX_W'(IX_BASE2): rd_val = bar2_q;
      IDX_W'(IX_CTRL):  rd_val = ctl_q;
      IDX_W'(IX_STAT):  rd_val = stat_q;
      default:          rd_val = '1;
    endcase
    for (int i = 0; i < PLAIN_N; i++) begin
      if (acc_idx == IDX_W'(plain_ix(i))) rd_val = plain_q[i];
    end
  end

  assign rd    = acc_vld & ~acc_we;
  assign sc_ld = rd & acc_scan;
  assign mm_ld = rd & ~acc_scan;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_rdata  <= '0;
      sc_rvalid <= 1'b0;
      mm_rdata  <= '0;
      mm_rvalid <= 1'b0;
    end else begin
      sc_rvalid <= sc_ld;
      mm_rvalid <= mm_ld;
      if (sc_ld) sc_rdata <= rd_val;
      if (mm_ld) mm_rdata <= rd_val;
    end
  end
endmodule

// File: rtl/svc_bridge_regs.sv
module svc_bridge_regs
  import svcb_pkg::*;
#(
  parameter int                ADDR_W  = 8,
  parameter logic [DATA_W-1:0] DEF_BAR = 64'h0001_2345_6780_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sc_req,
  input  logic              sc_we,
  input  logic [ADDR_W-1:0] sc_addr,
  input  logic [63:0]       sc_wdata,
  output logic              sc_ready,
  output logic [63:0]       sc_rdata,
  output logic              sc_rvalid,
  input  logic              mm_req,
  input  logic              mm_we,
  input  logic [ADDR_W-1:0] mm_addr,
  input  logic [63:0]       mm_wdata,
  output logic              mm_ready,
  output logic [63:0]       mm_rdata,
  output logic              mm_rvalid,
  input  logic [63:0]       stat_in,
  output logic [63:0]       region_base,
  output logic              region_en,
  output logic              remap_pulse,
  output logic              err_pulse
);
  localparam int IDX_W = ADDR_W - 2;

  logic [1:0]                     rst_pipe;
  logic                           rst_sync_n;
  logic                           acc_vld;
  logic                           acc_we;
  logic                           acc_scan;
  logic [IDX_W-1:0]               acc_idx;
  logic [DATA_W-1:0]              acc_wdata;
  logic [DATA_W-1:0]              fir_q;
  logic [DATA_W-1:0]              ctl_q;
  logic [DATA_W-1:0]              bar_q;
  logic [DATA_W-1:0]              bar2_q;
  logic [DATA_W-1:0]              stat_q;
  logic [PLAIN_N-1:0][DATA_W-1:0] plain_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  svcb_arb #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_arb (
    .sc_req   (sc_req),
    .sc_we    (sc_we),
    .sc_addr  (sc_addr),
    .sc_wdata (sc_wdata),
    .sc_ready (sc_ready),
    .mm_req   (mm_req),
    .mm_we    (mm_we),
    .mm_addr  (mm_addr),
    .mm_wdata (mm_wdata),
    .mm_ready (mm_ready),
    .acc_vld  (acc_vld),
    .acc_we   (acc_we),
    .acc_scan (acc_scan),
    .acc_idx  (acc_idx),
    .acc_wdata(acc_wdata)
  );

  svcb_regfile #(.IDX_W(IDX_W), .DEF_BAR(DEF_BAR)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .acc_vld    (acc_vld),
    .acc_we     (acc_we),
    .acc_scan   (acc_scan),
    .acc_idx    (acc_idx),
    .acc_wdata  (acc_wdata),
    .stat_in    (stat_in),
    .fir_q      (fir_q),
    .ctl_q      (ctl_q),
    .bar_q      (bar_q),
    .bar2_q     (bar2_q),
    .stat_q     (stat_q),
    .plain_q    (plain_q),
    .err_pulse  (err_pulse),
    .remap_pulse(remap_pulse)
  );

  svcb_readback #(.IDX_W(IDX_W)) u_rdbk (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .acc_vld  (acc_vld),
    .acc_we   (acc_we),
    .acc_scan (acc_scan),
    .acc_idx  (acc_idx),
    .fir_q    (fir_q),
    .ctl_q    (ctl_q),
    .bar_q    (bar_q),
    .bar2_q   (bar2_q),
    .stat_q   (stat_q),
    .plain_q  (plain_q),
    .sc_rdata (sc_rdata),
    .sc_rvalid(sc_rvalid),
    .mm_rdata (mm_rdata),
    .mm_rvalid(mm_rvalid)
  );

  assign region_base = bar_q & BASE_ADDR_MASK;
  assign region_en   = bar_q[0];
endmodule

// File: rtl/svcb_checker.sv
module svcb_checker #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sc_req,
  input logic              sc_we,
  input logic [ADDR_W-4:0] sc_word,
  input logic [63:0]       sc_wdata,
  input logic              sc_rvalid,
  input logic              mm_req,
  input logic              mm_we,
  input logic [ADDR_W-4:0] mm_word,
  input logic              mm_ready,
  input logic              mm_rvalid,
  input logic [63:0]       region_base,
  input logic              region_en,
  input logic              remap_pulse,
  input logic              err_pulse,
  input logic [63:0]       fir_q,
  input logic [63:0]       ctl_q
);
  // R3: OR alias merges data into the fault register
  assert_fault_or_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_req && sc_we && sc_word == 2) |=> (fir_q == ($past(fir_q) | $past(sc_wdata))));

  // R4: clear alias removes bits from the control register
  assert_ctrl_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_req && sc_we && sc_word == 19) |=> (ctl_q == ($past(ctl_q) & ~$past(sc_wdata))));

  // R5: memory-mapped base write is refused
  assert_base_mm_refused_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_req && mm_ready && mm_we && mm_word == 0)
      |=> (err_pulse && $stable(region_base) && $stable(region_en)));

  // R9: scan port served on collision
  assert_scan_priority_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_req && !sc_we && mm_req && !mm_we) |=> (sc_rvalid && !mm_rvalid));

  // R10: accepted read returns next cycle
  assert_mm_read_resp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_req && mm_ready && !mm_we) |=> mm_rvalid);

  // R11: remap only follows a scan base write
  assert_remap_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    remap_pulse |-> $past(sc_req && sc_we && sc_word == 10));
endmodule

bind svc_bridge_regs svcb_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .sc_req     (sc_req),
  .sc_we      (sc_we),
  .sc_word    (sc_addr[ADDR_W-1:3]),
  .sc_wdata   (sc_wdata),
  .sc_rvalid  (sc_rvalid),
  .mm_req     (mm_req),
  .mm_we      (mm_we),
  .mm_word    (mm_addr[ADDR_W-1:3]),
  .mm_ready   (mm_ready),
  .mm_rvalid  (mm_rvalid),
  .region_base(region_base),
  .region_en  (region_en),
  .remap_pulse(remap_pulse),
  .err_pulse  (err_pulse),
  .fir_q      (fir_q),
  .ctl_q      (ctl_q)
);

// File: tb/svc_bridge_regs_test.sv
`timescale 1ns/1ps
module svc_bridge_regs_test;
  localparam logic [63:0] DEF_BAR = 64'h0001_2345_6780_0000;
  localparam logic [63:0] BMASK   = 64'h0003_FFFF_FFF0_0000;
  localparam logic [63:0] SMASK   = 64'h0003_FFFF_0000_0000;

  logic        clk, rst_n;
  logic        sc_req, sc_we, sc_ready, sc_rvalid;
  logic [7:0]  sc_addr;
  logic [63:0] sc_wdata, sc_rdata;
  logic        mm_req, mm_we, mm_ready, mm_rvalid;
  logic [7:0]  mm_addr;
  logic [63:0] mm_wdata, mm_rdata;
  logic [63:0] stat_in, region_base;
  logic        region_en, remap_pulse, err_pulse;

  int          n_chk, n_fail;
  logic [63:0] m [64];

  svc_bridge_regs #(.ADDR_W(8), .DEF_BAR(DEF_BAR)) uut (
    .clk(clk), .rst_n(rst_n),
    .sc_req(sc_req), .sc_we(sc_we), .sc_addr(sc_addr), .sc_wdata(sc_wdata),
    .sc_ready(sc_ready), .sc_rdata(sc_rdata), .sc_rvalid(sc_rvalid),
    .mm_req(mm_req), .mm_we(mm_we), .mm_addr(mm_addr), .mm_wdata(mm_wdata),
    .mm_ready(mm_ready), .mm_rdata(mm_rdata), .mm_rvalid(mm_rvalid),
    .stat_in(stat_in), .region_base(region_base), .region_en(region_en),
    .remap_pulse(remap_pulse), .err_pulse(err_pulse)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  function automatic bit impl(int i);
    return (i == 0 || i == 6 || i == 7 || i == 10 || i == 11 ||
            i == 14 || i == 15 || i == 20 || i == 21);
  endfunction

  function automatic logic [63:0] exp_rd(int i);
    if (i == 21) return stat_in;
    return impl(i) ? m[i] : 64'hFFFF_FFFF_FFFF_FFFF;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 64; i++) m[i] = '0;
    m[10] = (DEF_BAR & BMASK) | 64'h1;
  endtask

  task automatic model_wr(bit scan, int idx, logic [63:0] d, output bit e, output bit r);
    e = 0; r = 0;
    case (idx)
      0:  m[0] = d;
      1:  m[0] = m[0] & d;
      2:  m[0] = m[0] | d;
      6, 7, 15, 20: m[idx] = d;
      10: if (scan) begin r = m[10][0] | d[0]; m[10] = d & (BMASK | 64'h1); end
          else e = 1;
      11: m[11] = d & SMASK;
      14: m[14] = d;
      18: m[14] = m[14] | d;
      19: m[14] = m[14] & ~d;
      default: e = 1;
    endcase
  endtask

  task automatic access(bit scan, bit we, logic [7:0] a, logic [63:0] d,
                        output logic [63:0] rd, output logic rv);
    if (scan) begin sc_req = 1; sc_we = we; sc_addr = a; sc_wdata = d; end
    else      begin mm_req = 1; mm_we = we; mm_addr = a; mm_wdata = d; end
    @(posedge clk); #1;
    sc_req = 0; mm_req = 0;
    rd = scan ? sc_rdata : mm_rdata;
    rv = scan ? sc_rvalid : mm_rvalid;
  endtask

  task automatic wr(bit scan, logic [7:0] a, logic [63:0] d, string tag);
    int idx; bit e, r; logic [63:0] rd; logic rv;
    idx = scan ? int'(a >> 3) : int'(a >> 3) + 10;
    model_wr(scan, idx, d, e, r);
    access(scan, 1'b1, a, d, rd, rv);
    chk({tag, " R7/R13 err_pulse"}, {63'd0, err_pulse}, {63'd0, e});
    chk({tag, " R11 remap_pulse"}, {63'd0, remap_pulse}, {63'd0, r});
    chk({tag, " R10 no rvalid on write"}, {63'd0, rv}, 64'd0);
    chk({tag, " R11 region_base"}, region_base, m[10] & BMASK);
    chk({tag, " R11 region_en"}, {63'd0, region_en}, {63'd0, m[10][0]});
  endtask

  task automatic rdchk(bit scan, logic [7:0] a, string tag);
    int idx; logic [63:0] rd; logic rv;
    idx = scan ? int'(a >> 3) : int'(a >> 3) + 10;
    access(scan, 1'b0, a, '0, rd, rv);
    chk({tag, " R10 rvalid"}, {63'd0, rv}, 64'd1);
    chk($sformatf("%s R2 idx %0d data", tag, idx), rd, exp_rd(idx));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog: actual hung expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [63:0] d;
    n_chk = 0; n_fail = 0;
    sc_req = 0; sc_we = 0; sc_addr = 0; sc_wdata = 0;
    mm_req = 0; mm_we = 0; mm_addr = 0; mm_wdata = 0;
    stat_in = 64'hC3C3_0000_1234_5678;
    rst_n = 0;
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    #1;

    // R1: reset state through both ports
    chk("R1 region_en after reset", {63'd0, region_en}, 64'd1);
    chk("R1 region_base after reset", region_base, DEF_BAR & BMASK);
    chk("R9 mm_ready idle", {63'd0, mm_ready}, 64'd1);
    for (int i = 0; i < 32; i++) rdchk(1'b1, 8'(i * 8), "R1 scan reset sweep");
    for (int i = 0; i < 32; i++) rdchk(1'b0, 8'(i * 8), "R1 mm reset sweep");

    // R3: fault register aliases
    wr(1'b1, 8'h00, 64'hF0F0_F0F0_1234_5678, "R3 fault load");
    wr(1'b1, 8'h08, 64'hFF00_FF00_FFFF_0000, "R3 fault AND");
    rdchk(1'b1, 8'h00, "R3 after AND");
    wr(1'b1, 8'h10, 64'h0000_000F_0000_000F, "R3 fault OR");
    rdchk(1'b1, 8'h00, "R3 after OR");

    // R4: control set/clear aliases, one through the mapped window
    wr(1'b1, 8'h70, 64'h8000_0000_0000_0001, "R4 ctrl load");
    wr(1'b1, 8'h90, 64'h4400_0000_0000_0100, "R4 ctrl set");
    wr(1'b0, 8'h48, 64'h8000_0000_0000_0001, "R4 ctrl clear via mm");
    rdchk(1'b0, 8'h20, "R4 ctrl via mm");

    // R5/R11: base register
    wr(1'b1, 8'h50, 64'hFFFF_FFFF_FFFF_FFFE, "R5 base disable");
    wr(1'b1, 8'h50, 64'hFFFF_FFFF_FFFF_FFFE, "R11 base stays disabled");
    wr(1'b1, 8'h50, 64'h0002_0000_0030_0001, "R5 base enable");
    wr(1'b0, 8'h00, 64'h0000_0000_0000_0000, "R5 mm base refused");
    rdchk(1'b1, 8'h50, "R5 base unchanged");

    // R6: secondary base mask
    wr(1'b0, 8'h08, 64'hFFFF_FFFF_FFFF_FFFF, "R6 base2");
    rdchk(1'b1, 8'h58, "R6 base2 readback");

    // R8: status read-only and sampled
    wr(1'b1, 8'hA8, 64'h0, "R8 status write");
    rdchk(1'b1, 8'hA8, "R8 status unchanged");
    stat_in = 64'h0000_0001_F000_0000;
    @(posedge clk); #1;
    rdchk(1'b0, 8'h58, "R8 status new sample");

    // R7/R13: unmatched write pulse lasts one cycle
    wr(1'b1, 8'hF8, 64'h1234, "R7 unmatched write");
    @(posedge clk); #1;
    chk("R13 err_pulse drops", {63'd0, err_pulse}, 64'd0);
    rdchk(1'b1, 8'h08, "R7 alias read all ones");

    // R9: collision
    sc_req = 1; sc_we = 0; sc_addr = 8'h70;
    mm_req = 1; mm_we = 0; mm_addr = 8'h08;
    #1;
    chk("R9 mm_ready low on collision", {63'd0, mm_ready}, 64'd0);
    @(posedge clk); #1;
    chk("R9 scan served", {63'd0, sc_rvalid}, 64'd1);
    chk("R9 scan data", sc_rdata, m[14]);
    chk("R9 mm held", {63'd0, mm_rvalid}, 64'd0);
    sc_req = 0;
    #1;
    chk("R9 mm_ready after release", {63'd0, mm_ready}, 64'd1);
    @(posedge clk); #1;
    mm_req = 0;
    chk("R9 mm served later", {63'd0, mm_rvalid}, 64'd1);
    chk("R9 mm data", mm_rdata, m[11]);
    @(posedge clk); #1;
    chk("R10 rvalid one cycle", {63'd0, mm_rvalid}, 64'd0);

    // R12 and full sweep through the scan port
    for (int i = 0; i < 32; i++) begin
      d = 64'h0123_4567_89AB_CDEF ^ ({8{8'(i)}} * 64'd3) ^ 64'(i & 1);
      wr(1'b1, 8'(i * 8), d, "R12 scan write sweep");
    end
    for (int i = 0; i < 32; i++) rdchk(1'b1, 8'(i * 8), "R12 scan readback");

    // sweep through the mapped window
    for (int i = 0; i < 32; i++) begin
      d = 64'hFEDC_BA98_7654_3210 ^ ({8{8'(i)}} << 1);
      wr(1'b0, 8'(i * 8), d, "R2 mm write sweep");
    end
    for (int i = 0; i < 32; i++) rdchk(1'b0, 8'(i * 8), "R2 mm readback");

    summary();
    $finish;
  end
endmodule